// File: doc/BRIEF.md
# Configurable Edge Discriminator with Hold-off

This block watches a stream of unsigned 14-bit ADC samples, one per clock, and decides when a signal edge has happened. Each channel picks one of two methods. The first is a slope comparison: the current sample minus the sample `d` clocks earlier is tested against a threshold. The second is constant fraction: an attenuated current sample minus the delayed sample is tracked, and the block fires when that signal swings back through the level it held just before the edge. Edge sensitivity can be rising, falling, or both. A programmable hold-off stops one edge from producing more than one firing.

A second slope comparator shares the delay line and has its own threshold. It acts as a coarse, early trigger, so a low setting fires it ahead of the main output on the same edge. A free-running 48-bit timestamp counter, cleared synchronously on command, is latched whenever the main output fires.

Top module: `edge_disc`

## Requirements
- R1: While `rst_ni` is low, `fire_o`, `coarse_fire_o`, `fire_ts_o` and `ts_o` are all zero.
- R2: With `mode_i`=0 (slope), a sample presented in cycle n gives a one-cycle pulse on `fire_o` in cycle n+1 when an enabled direction sees its signed difference above `thresh_i`. The rising difference is X(n)−X(n−d) and the falling difference is X(n−d)−X(n).
- R3: The delay d is `delay_i` for values 1 to 63. A value of 0 acts as 1.
- R4: `pol_i` bit 0 enables rising edges and bit 1 enables falling edges. With both bits set, the two directions are evaluated in parallel and their hits are ORed. With `pol_i`=00, neither output ever fires.
- R5: With `mode_i`=1 (constant fraction), the block computes s(n) = floor(X(n)·`frac_i`/256) − X(n−d). An enabled direction arms when its difference exceeds `thresh_i`, and at that moment it latches s(n−1) as its reference. An armed rising direction fires when s ≤ reference, and an armed falling direction fires when s ≥ reference.
- R6: A main firing reloads a hold-off counter with `holdoff_i`. While that counter is nonzero, the main output cannot fire and no direction can arm. A firing also clears both armed directions.
- R7: `coarse_fire_o` is a slope comparison against `coarse_thresh_i`. It uses the same delay and polarity, has its own hold-off counter loaded from `holdoff_i`, and ignores `mode_i`.
- R8: `fire_ts_o` takes the `ts_o` value of the cycle in which the firing sample was presented. It holds that value until the next main firing.
- R9: `ts_o` counts up by one every clock. When `ts_clear_i` is high, the counter reads zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 14 | ADC sample, unsigned |
| ts_clear_i | input | 1 | Synchronous timestamp clear |
| mode_i | input | 1 | 0 slope, 1 constant fraction |
| pol_i | input | 2 | Bit 0 rising, bit 1 falling |
| delay_i | input | 6 | Comparison delay d |
| thresh_i | input | 14 | Main threshold |
| coarse_thresh_i | input | 14 | Coarse threshold |
| frac_i | input | 8 | Fraction, scaled by 1/256 |
| holdoff_i | input | 16 | Hold-off length in cycles |
| fire_o | output | 1 | Main fire pulse |
| coarse_fire_o | output | 1 | Coarse fire pulse |
| fire_ts_o | output | 48 | Timestamp of last main firing |
| ts_o | output | 48 | Running timestamp |

## Verification
The hardest state to reach is an armed constant-fraction direction whose zero crossing falls inside or right after a hold-off window, especially with both polarities enabled and a long delay. The bench reaches it by first flushing the 63-deep history with a flat baseline. It then sweeps mode, polarity, delay (0, 1, 5, 63), hold-off and fraction over a waveform of slow ramps both ways, a train of closely spaced spikes, and full-scale steps. Every cycle is compared against an arithmetic model of the requirements.

// File: rtl/disc_pkg.sv
package disc_pkg;
  typedef enum logic {
    MODE_SLOPE = 1'b0,
    MODE_CFD   = 1'b1
  } disc_mode_e;

  localparam int unsigned NUM_DIR = 2;  // 0 rising, 1 falling
endpackage

// File: rtl/disc_delay_line.sv
module disc_delay_line #(
  parameter int unsigned SW    = 14,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned DLYW = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SW-1:0]   din_i,
  input  logic [DLYW-1:0] dly_i,
  output logic [SW-1:0]   tap_o
);
  logic [SW-1:0]   hist_q [DEPTH];
  logic [DLYW-1:0] dly_eff;
  logic [DLYW-1:0] tap_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else begin
      hist_q[0] <= din_i;
      for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  // hist_q[0] already holds X(n-1)
  always_comb begin
    dly_eff = (dly_i == '0) ? DLYW'(1) : dly_i;
    tap_idx = DLYW'(dly_eff - DLYW'(1));
    tap_o   = hist_q[tap_idx];
  end
endmodule

// File: rtl/disc_arm.sv
module disc_arm #(
  parameter int unsigned DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 clr_i,
  input  logic signed [DW-1:0] dif_i,
  input  logic signed [DW-1:0] thr_i,
  input  logic signed [DW-1:0] cfd_i,
  input  logic signed [DW-1:0] cfd_prev_i,
  output logic                 fire_o
);
  logic                 armed_q;
  logic signed [DW-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      ref_q   <= '0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
    end else if (!armed_q && en_i && (dif_i > thr_i)) begin
      armed_q <= 1'b1;
      ref_q   <= cfd_prev_i;
    end
  end

  // inputs arrive sign-normalised: a crossing is always a fall back to the reference
  assign fire_o = en_i && armed_q && (cfd_i <= ref_q);
endmodule

// File: rtl/disc_holdoff.sv
module disc_holdoff #(
  parameter int unsigned HOW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           raw_i,
  input  logic [HOW-1:0] len_i,
  output logic           fire_now_o,
  output logic           busy_o,
  output logic           fire_o
);
  logic [HOW-1:0] cnt_q;

  assign busy_o     = (cnt_q != '0);
  assign fire_now_o = raw_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_o <= 1'b0;
    end else begin
      fire_o <= fire_now_o;
      if (fire_now_o)  cnt_q <= len_i;
      else if (busy_o) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/disc_ts_counter.sv
module disc_ts_counter #(
  parameter int unsigned TSW = 48
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  output logic [TSW-1:0] ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ts_o <= '0;
    else if (clr_i) ts_o <= '0;
    else            ts_o <= ts_o + 1'b1;
  end
endmodule

// File: rtl/edge_disc.sv
module edge_disc
  import disc_pkg::*;
#(
  parameter int unsigned SW    = 14,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned FW    = 8,
  parameter int unsigned HOW   = 16,
  parameter int unsigned TSW   = 48,
  localparam int unsigned DLYW = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SW-1:0]   sample_i,
  input  logic            ts_clear_i,
  input  logic            mode_i,
  input  logic [1:0]      pol_i,
  input  logic [DLYW-1:0] delay_i,
  input  logic [SW-1:0]   thresh_i,
  input  logic [SW-1:0]   coarse_thresh_i,
  input  logic [FW-1:0]   frac_i,
  input  logic [HOW-1:0]  holdoff_i,
  output logic            fire_o,
  output logic            coarse_fire_o,
  output logic [TSW-1:0]  fire_ts_o,
  output logic [TSW-1:0]  ts_o
);
  localparam int unsigned DW = SW + 2;
  localparam int unsigned PW = SW + FW;

  logic [SW-1:0]        old_smp;
  logic [PW-1:0]        prod;
  logic signed [DW-1:0] cur_s, old_s, diff_s, cfd_s, cfd_prev_q, thr_s, cthr_s;
  logic [NUM_DIR-1:0]   le_hit, co_hit, cfd_hit;
  logic                 is_cfd, raw_main, raw_coarse;
  logic                 fire_now, main_busy, arm_clr;
  logic                 co_fire_now, co_busy;
  logic [TSW-1:0]       fire_ts_q;

  disc_delay_line #(.SW(SW), .DEPTH(DEPTH)) i_dline (
    .clk_i, .rst_ni, .din_i(sample_i), .dly_i(delay_i), .tap_o(old_smp)
  );

  disc_ts_counter #(.TSW(TSW)) i_ts (
    .clk_i, .rst_ni, .clr_i(ts_clear_i), .ts_o(ts_o)
  );

  always_comb begin
    cur_s  = $signed({2'b00, sample_i});
    old_s  = $signed({2'b00, old_smp});
    diff_s = cur_s - old_s;
    prod   = PW'(sample_i) * PW'(frac_i);
    cfd_s  = $signed({2'b00, prod[PW-1:FW]}) - old_s;
    thr_s  = $signed({2'b00, thresh_i});
    cthr_s = $signed({2'b00, coarse_thresh_i});
    is_cfd = (disc_mode_e'(mode_i) == MODE_CFD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfd_prev_q <= '0;
    else         cfd_prev_q <= cfd_s;
  end

  assign arm_clr = !is_cfd || main_busy || fire_now;

  for (genvar k = 0; k < NUM_DIR; k++) begin : g_dir
    logic signed [DW-1:0] dif_k, cfd_k, prev_k;
    if (k == 0) begin : g_rise
      assign dif_k  = diff_s;
      assign cfd_k  = cfd_s;
      assign prev_k = cfd_prev_q;
    end else begin : g_fall
      assign dif_k  = -diff_s;
      assign cfd_k  = -cfd_s;
      assign prev_k = -cfd_prev_q;
    end

    assign le_hit[k] = pol_i[k] && (dif_k > thr_s);
    assign co_hit[k] = pol_i[k] && (dif_k > cthr_s);

    disc_arm #(.DW(DW)) i_arm (
      .clk_i, .rst_ni,
      .en_i      (pol_i[k]),
      .clr_i     (arm_clr),
      .dif_i     (dif_k),
      .thr_i     (thr_s),
      .cfd_i     (cfd_k),
      .cfd_prev_i(prev_k),
      .fire_o    (cfd_hit[k])
    );
  end

  assign raw_main   = is_cfd ? |cfd_hit : |le_hit;
  assign raw_coarse = |co_hit;

  disc_holdoff #(.HOW(HOW)) i_ho_main (
    .clk_i, .rst_ni, .raw_i(raw_main), .len_i(holdoff_i),
    .fire_now_o(fire_now), .busy_o(main_busy), .fire_o(fire_o)
  );

  disc_holdoff #(.HOW(HOW)) i_ho_coarse (
    .clk_i, .rst_ni, .raw_i(raw_coarse), .len_i(holdoff_i),
    .fire_now_o(co_fire_now), .busy_o(co_busy), .fire_o(coarse_fire_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fire_ts_q <= '0;
    else if (fire_now) fire_ts_q <= ts_o;
  end

  assign fire_ts_o = fire_ts_q;
endmodule

// File: rtl/edge_disc_chk.sv
module edge_disc_chk #(
  parameter int unsigned HOW = 16,
  parameter int unsigned TSW = 48
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ts_clear_i,
  input logic [1:0]     pol_i,
  input logic [HOW-1:0] holdoff_i,
  input logic           fire_o,
  input logic           coarse_fire_o,
  input logic [TSW-1:0] fire_ts_o,
  input logic [TSW-1:0] ts_o
);
  AST_HOLDOFF_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && $past(holdoff_i) != '0) |=> !fire_o);  // R6

  AST_HOLDOFF_COARSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coarse_fire_o && $past(holdoff_i) != '0) |=> !coarse_fire_o);  // R7

  AST_POL_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pol_i) == 2'b00) |-> (!fire_o && !coarse_fire_o));  // R4

  AST_TS_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (fire_ts_o == $past(ts_o)));  // R8

  AST_TS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_o |-> $stable(fire_ts_o));  // R8

  AST_TS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_clear_i |=> (ts_o == '0));  // R9

  AST_TS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(ts_clear_i)) |-> (ts_o == $past(ts_o) + TSW'(1)));  // R9
endmodule

bind edge_disc edge_disc_chk #(.HOW(HOW), .TSW(TSW)) i_chk (.*);

// File: tb/test_edge_disc.sv
module test_edge_disc;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 14, DEPTH = 64, FW = 8, HOW = 16, TSW = 48;
  localparam int BASE = 8192;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic [SW-1:0]   sample_i;
  logic            ts_clear_i;
  logic            mode_i;
  logic [1:0]      pol_i;
  logic [5:0]      delay_i;
  logic [SW-1:0]   thresh_i, coarse_thresh_i;
  logic [FW-1:0]   frac_i;
  logic [HOW-1:0]  holdoff_i;
  logic            fire_o, coarse_fire_o;
  logic [TSW-1:0]  fire_ts_o, ts_o;

  edge_disc #(.SW(SW), .DEPTH(DEPTH), .FW(FW), .HOW(HOW), .TSW(TSW)) i_edge_disc (
    .clk_i, .rst_ni, .sample_i, .ts_clear_i, .mode_i, .pol_i, .delay_i,
    .thresh_i, .coarse_thresh_i, .frac_i, .holdoff_i,
    .fire_o, .coarse_fire_o, .fire_ts_o, .ts_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";

  int     m_hist [DEPTH];
  int     m_sprev, m_cnt, m_ccnt;
  bit     m_arm [2];
  int     m_ref [2];
  longint m_ts, e_fts;
  bit     e_fire, e_cfire;

  task automatic check(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_hist[i] = 0;
    m_sprev = 0; m_cnt = 0; m_ccnt = 0; m_ts = 0; e_fts = 0;
    e_fire = 0; e_cfire = 0;
    for (int k = 0; k < 2; k++) begin m_arm[k] = 0; m_ref[k] = 0; end
  endtask

  // one sample: predict, drive, clock, compare
  task automatic step(int smp, bit clr);
    int dly, old, diff, s, thr, cthr;
    int dk [2];
    bit le [2], co [2], cf [2];
    bit raw, fn, busy, craw, cfn, cbusy, arm_clr;
    dly  = (delay_i == 0) ? 1 : int'(delay_i);  // R3
    old  = m_hist[dly-1];
    diff = smp - old;
    s    = ((smp * int'(frac_i)) >>> 8) - old;
    thr  = int'(thresh_i);
    cthr = int'(coarse_thresh_i);
    for (int k = 0; k < 2; k++) begin
      dk[k] = (k == 0) ? diff : -diff;
      le[k] = pol_i[k] && (dk[k] > thr);
      co[k] = pol_i[k] && (dk[k] > cthr);
      cf[k] = pol_i[k] && m_arm[k] && ((k == 0) ? (s <= m_ref[k]) : (s >= m_ref[k]));
    end
    raw  = mode_i ? (cf[0] || cf[1]) : (le[0] || le[1]);
    busy = (m_cnt != 0);
    fn   = raw && !busy;
    m_cnt = fn ? int'(holdoff_i) : (busy ? m_cnt - 1 : 0);
    craw  = co[0] || co[1];
    cbusy = (m_ccnt != 0);
    cfn   = craw && !cbusy;
    m_ccnt = cfn ? int'(holdoff_i) : (cbusy ? m_ccnt - 1 : 0);
    arm_clr = !mode_i || busy || fn;
    for (int k = 0; k < 2; k++) begin
      if (arm_clr) m_arm[k] = 0;
      else if (!m_arm[k] && pol_i[k] && dk[k] > thr) begin
        m_arm[k] = 1;
        m_ref[k] = m_sprev;
      end
    end
    m_sprev = s;
    for (int i = DEPTH-1; i > 0; i--) m_hist[i] = m_hist[i-1];
    m_hist[0] = smp;
    e_fire  = fn;
    e_cfire = cfn;
    if (fn) e_fts = m_ts;
    m_ts = clr ? 0 : m_ts + 1;

    sample_i   = SW'(smp);
    ts_clear_i = clr;
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag,  "fire_o",        longint'(fire_o),        longint'(e_fire));
    check("R7", "coarse_fire_o", longint'(coarse_fire_o), longint'(e_cfire));
    check("R8", "fire_ts_o",     longint'(fire_ts_o),     e_fts);
    check("R9", "ts_o",          longint'(ts_o),          m_ts);
  endtask

  // baseline, slow ramps both ways, spike train, baseline
  task automatic run_wave(bit clr_mid);
    int v;
    for (int i = 0; i < 70; i++) step(BASE, 1'b0);
    for (int i = 1; i <= 8; i++) step(BASE + 125*i, 1'b0);
    for (int i = 0; i < 40; i++) step(BASE + 1000, clr_mid && (i == 20));
    for (int i = 7; i >= 0; i--) step(BASE + 125*i, 1'b0);
    for (int i = 0; i < 40; i++) step(BASE, 1'b0);
    for (int i = 0; i < 24; i++) begin
      v = (i % 3 == 0) ? BASE + 400 : BASE;
      step(v, 1'b0);
    end
    for (int i = 0; i < 70; i++) step(BASE, 1'b0);
  endtask

  task automatic run_extreme();
    for (int i = 0; i < 70; i++) step(0, 1'b0);
    for (int i = 0; i < 70; i++) step(16383, 1'b0);
    for (int i = 0; i < 70; i++) step(0, 1'b0);
  endtask

  task automatic make_tag(int d, int ho);
    tag = mode_i ? "R5" : "R2";
    if (d == 0 || d == 63) tag = {tag, " R3"};
    if (pol_i != 2'b01)    tag = {tag, " R4"};
    if (ho != 0)           tag = {tag, " R6"};
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int dlys [4];
    int fracs [3];
    int idx;
    dlys  = '{0, 1, 5, 63};
    fracs = '{64, 160, 255};
    rst_ni = 1'b0; sample_i = '0; ts_clear_i = 1'b0; mode_i = 1'b0; pol_i = 2'b01;
    delay_i = 6'd1; thresh_i = 14'd100; coarse_thresh_i = 14'd30; frac_i = 8'd128;
    holdoff_i = '0;
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", "fire_o",        longint'(fire_o),        0);
    check("R1", "coarse_fire_o", longint'(coarse_fire_o), 0);
    check("R1", "fire_ts_o",     longint'(fire_ts_o),     0);
    check("R1", "ts_o",          longint'(ts_o),          0);
    rst_ni = 1'b1;

    idx = 0;
    // sweep R2/R5 modes, R4 polarity, R3 delay, R6 hold-off, fraction
    for (int md = 0; md < 2; md++) begin
      for (int p = 0; p < 4; p++) begin
        for (int di = 0; di < 4; di++) begin
          for (int ho = 0; ho < 2; ho++) begin
            for (int fi = 0; fi < (md ? 3 : 1); fi++) begin
              mode_i    = md[0];
              pol_i     = p[1:0];
              delay_i   = 6'(dlys[di]);
              holdoff_i = HOW'(ho * 3);
              frac_i    = FW'(fracs[fi]);
              make_tag(dlys[di], ho * 3);
              run_wave(idx[0]);
              idx++;
            end
          end
        end
      end
    end

    // full-scale steps, both modes, both directions
    frac_i = 8'd255; delay_i = 6'd63; holdoff_i = HOW'(5);
    for (int md = 0; md < 2; md++) begin
      for (int p = 1; p < 4; p++) begin
        mode_i = md[0];
        pol_i  = p[1:0];
        make_tag(63, 5);
        run_extreme();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule